// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer execute stage of a small processor core. Each cycle it takes two register operands, a four-bit operation code, an incoming carry bit and a request to set flags. From these it computes the result, a register write enable and the next value of the four condition flags. The flags are negative, zero, carry and overflow, packed as {N, Z, C, V}. The datapath is purely combinational. The only state is a flags register, which loads the next-flags value on the clock edge whenever the flag-update strobe is high.

Operations fall into three groups. The arithmetic group covers add, add with carry, subtract, subtract with carry, reverse subtract and reverse subtract with carry. The logic group covers AND, OR, XOR, bit-clear, move and move-inverted. The compare group covers compare, compare-negative, test and test-equivalence. Compare-type operations update only the flags and never write a register. All other operations update the flags only on request.

Top module: `flag_alu`

## Requirements
- R1: Opcode 4 (add) yields A + B. Opcode 5 (add with carry) yields A + B + carry_in. In both cases C is bit 32 of the unsigned sum.
- R2: Opcode 2 (subtract) yields A - B. Opcode 6 (subtract with carry) yields A - B + carry_in - 1. In both cases C is 1 exactly when no borrow occurs.
- R3: Opcode 3 (reverse subtract) yields B - A. Opcode 7 (reverse with carry) yields B - A + carry_in - 1. C is 1 when no borrow occurs.
- R4: The logic operations are opcode 0 (A AND B), 12 (A OR B), 1 (A XOR B) and 14 (bit-clear, A AND NOT B).
- R5: Opcode 13 (move) passes B unchanged, and opcode 15 (move-inverted) yields NOT B.
- R6: Opcodes 8 to 11 are the compare group: test (A AND B), test-equivalence (A XOR B), compare (A - B) and compare-negative (A + B). They always raise flag_upd, never raise wr_en, and their flags follow those values. Every other opcode raises wr_en.
- R7: The flag vector is {N, Z, C, V}, bits 3 down to 0. N equals result bit 31, and Z is 1 exactly when the 32-bit result is zero.
- R8: For every arithmetic and compare-arithmetic opcode, V is 1 exactly when the exact signed value falls outside the 32-bit signed range.
- R9: The logic, move and test opcodes pass the stored C and V bits through unchanged into flags_next.
- R10: flags_q loads flags_next on a clock edge when flag_upd is high and holds otherwise. For non-compare opcodes, flag_upd equals set_flags.
- R11: While rst_n is low, flags_q is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flags register |
| rst_n | input | 1 | Active-low reset, clears stored flags |
| op_a | input | 32 | First operand (A) |
| op_b | input | 32 | Second operand (B) |
| op_code | input | 4 | Operation select |
| carry_in | input | 1 | Carry used by the carry forms |
| set_flags | input | 1 | Request to update flags for non-compare operations |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Register write enable |
| flags_next | output | 4 | Next flags {N,Z,C,V} |
| flag_upd | output | 1 | Flags register load strobe |
| flags_q | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The bench targets the carry edges of the subtract family. These are equal operands, a minuend of zero and subtract-with-carry with carry_in low. A design that stored the raw borrow instead of its inverse would flip C on all of them. A design that added the carry unconditionally would produce results off by one. Signed overflow is probed at both ends of the range, for example 0x7FFFFFFF + 1 and 0x80000000 - 1, where a check based on the carry bit would give the wrong V. The bench also issues compare ops with set_flags low and non-compare ops with set_flags low. It checks that compare ops still update flags_q without writing, and that non-compare ops leave flags_q intact on the next cycle. It also checks that logic ops with set_flags high keep the earlier C and V.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  function automatic logic op_is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
                       OP_CMP, OP_CMN});
  endfunction

  function automatic logic signed_ovf(input logic x_msb, input logic y_msb,
                                      input logic s_msb);
    return (x_msb == y_msb) && (s_msb != x_msb);
  endfunction

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int WS = W + 1;

  logic [W-1:0] x_opnd;
  logic [W-1:0] y_opnd;
  logic         c_opnd;
  logic [WS-1:0] wide;

  always_comb begin
    x_opnd = a;
    y_opnd = b;
    c_opnd = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: begin y_opnd = ~b; c_opnd = 1'b1; end
      OP_RSB:         begin x_opnd = b; y_opnd = ~a; c_opnd = 1'b1; end
      OP_ADC:         c_opnd = cin;
      OP_SBC:         begin y_opnd = ~b; c_opnd = cin; end
      OP_RSC:         begin x_opnd = b; y_opnd = ~a; c_opnd = cin; end
      default:        ;
    endcase
  end

  assign wide = {1'b0, x_opnd} + {1'b0, y_opnd} + WS'(c_opnd);
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  assign ovf  = signed_ovf(x_opnd[W-1], y_opnd[W-1], wide[W-1]);

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu_flagreg.sv
module flag_alu_flagreg #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NF-1:0] d,
  output logic [NF-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [3:0]    op_code,
  input  logic          carry_in,
  input  logic          set_flags,
  output logic [W-1:0]  result,
  output logic          wr_en,
  output logic [NF-1:0] flags_next,
  output logic          flag_upd,
  output logic [NF-1:0] flags_q
);
  // named internal events, observed by the bound checker
  logic         is_cmp_w;
  logic         is_arith_w;
  logic [W-1:0] add_sum_w;
  logic         add_cout_w;
  logic         add_ovf_w;
  logic [W-1:0] log_val_w;

  assign is_cmp_w   = op_is_compare(op_code);
  assign is_arith_w = op_is_arith(op_code);

  flag_alu_arith #(.W(W)) u_arith (
    .op(op_code), .a(op_a), .b(op_b), .cin(carry_in),
    .sum(add_sum_w), .cout(add_cout_w), .ovf(add_ovf_w)
  );

  flag_alu_logic #(.W(W)) u_logic (
    .op(op_code), .a(op_a), .b(op_b), .y(log_val_w)
  );

  assign result   = is_arith_w ? add_sum_w : log_val_w;
  assign wr_en    = !is_cmp_w;
  assign flag_upd = is_cmp_w || set_flags;

  always_comb begin
    flags_next         = '0;
    flags_next[FLAG_N] = result[W-1];
    flags_next[FLAG_Z] = (result == '0);
    flags_next[FLAG_C] = is_arith_w ? add_cout_w : flags_q[FLAG_C];
    flags_next[FLAG_V] = is_arith_w ? add_ovf_w  : flags_q[FLAG_V];
  end

  flag_alu_flagreg #(.NF(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .load(flag_upd), .d(flags_next), .q(flags_q)
  );

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W  = 32,
  parameter int NF = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  result,
  input logic          wr_en,
  input logic [NF-1:0] flags_next,
  input logic          flag_upd,
  input logic [NF-1:0] flags_q,
  input logic          is_cmp_w,
  input logic          is_arith_w
);
  // R6
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp_w |-> (!wr_en && flag_upd));

  // R7
  nz_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_next[3] == result[W-1]) && (flags_next[2] == (result == '0)));

  // R9
  logic_keep_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_arith_w |-> (flags_next[1:0] == flags_q[1:0]));

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_upd |=> $stable(flags_q));

  // R10
  flags_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> (flags_q == $past(flags_next)));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (flags_q == '0));
endmodule

bind flag_alu flag_alu_chk #(.W(W), .NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .result(result), .wr_en(wr_en),
  .flags_next(flags_next), .flag_upd(flag_upd), .flags_q(flags_q),
  .is_cmp_w(is_cmp_w), .is_arith_w(is_arith_w)
);

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0]  op_code = '0;
  logic        carry_in = 1'b0, set_flags = 1'b0;
  logic [31:0] result;
  logic        wr_en, flag_upd;
  logic [3:0]  flags_next, flags_q;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] r;
    logic        we;
    logic [3:0]  f;
    logic        up;
    logic [3:0]  q;
    string       tag;
  } item_t;

  item_t sb[$];
  logic [3:0] model_q = 4'b0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_alu u_flag_alu (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_code(op_code),
    .carry_in(carry_in), .set_flags(set_flags), .result(result),
    .wr_en(wr_en), .flags_next(flags_next), .flag_upd(flag_upd),
    .flags_q(flags_q)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: computes expectation from the requirements and queues it
  task automatic drive(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic cin, logic sf);
    item_t it;
    logic [32:0] wide;
    longint sa, sb_, sx;
    logic c, v, arith, cmp;
    sa = longint'($signed(a));
    sb_ = longint'($signed(b));
    wide = '0; sx = 0; arith = 1'b1;
    c = model_q[1]; v = model_q[0];
    case (op)
      4'd4, 4'd11: begin wide = {1'b0,a} + {1'b0,b}; sx = sa + sb_; c = wide[32]; end
      4'd5: begin wide = {1'b0,a} + {1'b0,b} + 33'(cin); sx = sa + sb_ + longint'(cin); c = wide[32]; end
      4'd2, 4'd10: begin wide = {1'b0,a} - {1'b0,b}; sx = sa - sb_; c = ~wide[32]; end
      4'd6: begin wide = {1'b0,a} - {1'b0,b} - 33'(!cin); sx = sa - sb_ - longint'(!cin); c = ~wide[32]; end
      4'd3: begin wide = {1'b0,b} - {1'b0,a}; sx = sb_ - sa; c = ~wide[32]; end
      4'd7: begin wide = {1'b0,b} - {1'b0,a} - 33'(!cin); sx = sb_ - sa - longint'(!cin); c = ~wide[32]; end
      default: begin
        arith = 1'b0;
        case (op)
          4'd0, 4'd8:  wide[31:0] = a & b;
          4'd1, 4'd9:  wide[31:0] = a ^ b;
          4'd12:       wide[31:0] = a | b;
          4'd13:       wide[31:0] = b;
          4'd14:       wide[31:0] = a & ~b;
          default:     wide[31:0] = ~b;
        endcase
      end
    endcase
    if (arith) v = (sx > 64'sd2147483647) || (sx < -64'sd2147483648);
    cmp = (op >= 4'd8) && (op <= 4'd11);
    it.r = wide[31:0];
    it.we = !cmp;
    it.f = {wide[31], wide[31:0] == 32'd0, c, v};
    it.up = cmp || sf;
    it.q = model_q;
    case (op)
      4'd4, 4'd5: it.tag = "R1";
      4'd2, 4'd6: it.tag = "R2";
      4'd3, 4'd7: it.tag = "R3";
      4'd13, 4'd15: it.tag = "R5";
      4'd8, 4'd9, 4'd10, 4'd11: it.tag = "R6";
      default: it.tag = "R4";
    endcase
    @(negedge clk);
    op_code = op; op_a = a; op_b = b; carry_in = cin; set_flags = sf;
    sb.push_back(it);
    if (it.up) model_q = it.f;
  endtask

  // monitor: pops expectations and compares after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, "result", result, it.r);
        check("R6", "wr_en", 32'(wr_en), 32'(it.we));
        check("R7/R8/R9", "flags_next", 32'(flags_next), 32'(it.f));
        check("R10", "flag_upd", 32'(flag_upd), 32'(it.up));
        check("R10", "flags_q", 32'(flags_q), 32'(it.q));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "flags_q in reset", 32'(flags_q), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "flags_q after reset", 32'(flags_q), 32'h0);

    // R1: plain add, carry out with zero, signed overflow (R8)
    drive(4'd4, 32'd5, 32'd7, 1'b0, 1'b1);
    drive(4'd4, 32'hFFFFFFFF, 32'd1, 1'b0, 1'b1);
    drive(4'd4, 32'h7FFFFFFF, 32'd1, 1'b0, 1'b1);
    drive(4'd5, 32'd10, 32'd20, 1'b1, 1'b1);
    drive(4'd5, 32'd10, 32'd20, 1'b0, 1'b1);
    // R2: equal operands, borrow from zero, carry forms
    drive(4'd2, 32'd9, 32'd9, 1'b0, 1'b1);
    drive(4'd2, 32'd0, 32'd1, 1'b0, 1'b1);
    drive(4'd2, 32'h80000000, 32'd1, 1'b0, 1'b1);
    drive(4'd6, 32'd9, 32'd4, 1'b0, 1'b1);
    drive(4'd6, 32'd9, 32'd4, 1'b1, 1'b1);
    // R3: reverse forms
    drive(4'd3, 32'd4, 32'd9, 1'b0, 1'b1);
    drive(4'd7, 32'd4, 32'd9, 1'b0, 1'b1);
    drive(4'd7, 32'd9, 32'd4, 1'b1, 1'b1);
    // R9: logic with set_flags keeps prior C and V
    drive(4'd4, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b1);
    drive(4'd0, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b0, 1'b1);
    drive(4'd12, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b0, 1'b1);
    drive(4'd1, 32'hAAAA5555, 32'hFFFF0000, 1'b0, 1'b1);
    drive(4'd14, 32'hFFFFFFFF, 32'h0000FFFF, 1'b0, 1'b1);
    // R5
    drive(4'd13, 32'h0, 32'h12345678, 1'b0, 1'b1);
    drive(4'd15, 32'h0, 32'h0, 1'b0, 1'b1);
    // R10: no set_flags leaves stored flags intact
    drive(4'd2, 32'd0, 32'd0, 1'b0, 1'b0);
    drive(4'd15, 32'h0, 32'hFFFFFFFF, 1'b0, 1'b0);
    // R6: compares update even without set_flags, never write
    drive(4'd10, 32'd3, 32'd3, 1'b0, 1'b0);
    drive(4'd11, 32'hFFFFFFFF, 32'd1, 1'b0, 1'b0);
    drive(4'd8, 32'hF0, 32'h0F, 1'b0, 1'b0);
    drive(4'd9, 32'h1234, 32'h1234, 1'b0, 1'b1);
    drive(4'd10, 32'h80000000, 32'd1, 1'b0, 1'b0);
    drive(4'd4, 32'd1, 32'd1, 1'b0, 1'b0);

    for (int i = 0; i < 400; i++) begin
      drive(4'($urandom), $urandom, (i % 7 == 0) ? 32'h80000000 : $urandom,
            1'($urandom), 1'($urandom));
    end

    @(negedge clk);
    #2;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule